// File: doc/BRIEF.md
# Dual-Set Carrier Generator

This block produces a rectangular carrier whose high and low phases are measured in ticks of a clock-enable input. Two count sets are held at the inputs, a primary one and a secondary one, each with an 8-bit high count and an 8-bit low count. A select input picks the set, so a modulator upstream can alternate between two carrier frequencies for frequency-shift keying. The carrier period is high plus low ticks, and the duty cycle is high divided by that sum.

Every period starts with its high phase. The select and the counts are sampled only when a period starts, so a change in the middle of a period never produces a runt pulse. A one-clock pulse marks each period boundary, which lets the modulator count carrier cycles. When the enable is low, the generator returns to idle and the carrier is held low.

Top module: `carrier_gen_dual`

## Requirements
- R1: While reset is asserted and after it is released with the enable low, `carrier_o` and `period_end_o` are 0.
- R2: After any clock edge at which `enable_i` is 0, `carrier_o` and `period_end_o` are 0. The next period starts afresh with a high phase on the first tick after the enable returns.
- R3: On the first clock edge with `enable_i` and `tick_i` both high after idle, `carrier_o` goes to 1 and stays 1 for exactly H ticks, where H is the selected high count.
- R4: After the high phase, `carrier_o` is 0 for exactly L ticks, where L is the selected low count, so the period is H+L ticks.
- R5: A high or low count of 0 behaves exactly like a count of 1.
- R6: `period_end_o` is 1 for exactly one clock after the tick that ends a low phase. In that same cycle `carrier_o` rises for the next period. At no other time is it 1.
- R7: `set_sel_i` = 0 selects the primary counts (`pri_high_i`, `pri_low_i`) and `set_sel_i` = 1 selects the secondary counts (`sec_high_i`, `sec_low_i`). The select is sampled only at the tick that starts a period.
- R8: The count inputs are sampled only at the tick that starts a period. Changes at any other time do not alter the period in progress.
- R9: On clock edges where `tick_i` is 0, the carrier level does not change and `period_end_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable; one tick is one unit of count |
| enable_i | input | 1 | Run when high; idle with the carrier low when low |
| pri_high_i | input | 8 | Primary set high-phase count |
| pri_low_i | input | 8 | Primary set low-phase count |
| sec_high_i | input | 8 | Secondary set high-phase count |
| sec_low_i | input | 8 | Secondary set low-phase count |
| set_sel_i | input | 1 | Count set select: 0 primary, 1 secondary |
| carrier_o | output | 1 | Carrier level |
| period_end_o | output | 1 | One-clock pulse at each period boundary |

## Verification
The end of one period and the loading of the next set happen on the same tick. The sharpest case is a select toggle or a count change applied exactly on the tick that closes a low phase. Random stimulus changes the select and the counts on arbitrary cycles, including those boundary ticks, with counts as small as one so that boundaries come often. A tick-level model in the bench latches whatever values are present on the boundary tick and compares the carrier and the boundary pulse on every cycle.

// File: rtl/cg_pkg.sv
package cg_pkg;

    localparam int unsigned CG_SETS = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } cg_phase_e;

endpackage

// File: rtl/cg_set_pick.sv
module cg_set_pick #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] pri_high_i,
    input  logic [CNT_W-1:0] pri_low_i,
    input  logic [CNT_W-1:0] sec_high_i,
    input  logic [CNT_W-1:0] sec_low_i,
    input  logic             set_sel_i,
    output logic [CNT_W-1:0] high_eff_o,
    output logic [CNT_W-1:0] low_eff_o
);
    import cg_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] raw_high [CG_SETS];
    logic [CNT_W-1:0] raw_low  [CG_SETS];
    logic [CNT_W-1:0] fix_high [CG_SETS];
    logic [CNT_W-1:0] fix_low  [CG_SETS];

    assign raw_high[0] = pri_high_i;
    assign raw_low[0]  = pri_low_i;
    assign raw_high[1] = sec_high_i;
    assign raw_low[1]  = sec_low_i;

    // A zero count is promoted to one so that no phase can collapse.
    for (genvar s = 0; s < CG_SETS; s++) begin : g_fix
        assign fix_high[s] = (raw_high[s] == '0) ? ONE : raw_high[s];
        assign fix_low[s]  = (raw_low[s]  == '0) ? ONE : raw_low[s];
    end

    assign high_eff_o = fix_high[set_sel_i];
    assign low_eff_o  = fix_low[set_sel_i];

endmodule

// File: rtl/cg_phase_core.sv
module cg_phase_core #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] high_eff_i,
    input  logic [CNT_W-1:0] low_eff_i,
    output logic             carrier_o,
    output logic             period_end_o
);
    import cg_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    typedef struct packed {
        cg_phase_e        ph;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] low_hold;
        logic             pend;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        if (!enable_i) begin
            st_d.ph       = PH_IDLE;
            st_d.rem      = '0;
            st_d.low_hold = '0;
        end else if (tick_i) begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    st_d.ph       = PH_HIGH;
                    st_d.rem      = high_eff_i;
                    st_d.low_hold = low_eff_i;
                end
                PH_HIGH: begin
                    if (st_q.rem == LAST) begin
                        st_d.ph  = PH_LOW;
                        st_d.rem = st_q.low_hold;
                    end else begin
                        st_d.rem = st_q.rem - LAST;
                    end
                end
                PH_LOW: begin
                    if (st_q.rem == LAST) begin
                        // Boundary: reload from whichever set is selected now.
                        st_d.ph       = PH_HIGH;
                        st_d.rem      = high_eff_i;
                        st_d.low_hold = low_eff_i;
                        st_d.pend     = 1'b1;
                    end else begin
                        st_d.rem = st_q.rem - LAST;
                    end
                end
                default: begin
                    st_d.ph  = PH_IDLE;
                    st_d.rem = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{ph: PH_IDLE, rem: '0, low_hold: '0, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign carrier_o    = (st_q.ph == PH_HIGH);
    assign period_end_o = st_q.pend;

    // R2: a disabled edge leaves the outputs quiet
    a_r2_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!carrier_o && !period_end_o));

    // R9: no tick, no movement
    a_r9_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !tick_i) |=> ($stable(st_q.ph) && $stable(st_q.rem) && !period_end_o));

    // R6: a boundary pulse coincides with a fresh high phase that follows a low phase
    a_r6_pulse_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_end_o |-> (carrier_o && $past(st_q.ph == PH_LOW)));

    // R6: the pulse lasts a single clock
    a_r6_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_end_o |=> !period_end_o);

    // R5: an active phase never holds a zero remaining count
    a_r5_no_zero_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph != PH_IDLE) |-> (st_q.rem != '0 && st_q.low_hold != '0));

endmodule

// File: rtl/carrier_gen_dual.sv
module carrier_gen_dual #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] pri_high_i,
    input  logic [CNT_W-1:0] pri_low_i,
    input  logic [CNT_W-1:0] sec_high_i,
    input  logic [CNT_W-1:0] sec_low_i,
    input  logic             set_sel_i,
    output logic             carrier_o,
    output logic             period_end_o
);

    logic [CNT_W-1:0] high_eff;
    logic [CNT_W-1:0] low_eff;

    cg_set_pick #(.CNT_W(CNT_W)) u_pick (
        .pri_high_i (pri_high_i),
        .pri_low_i  (pri_low_i),
        .sec_high_i (sec_high_i),
        .sec_low_i  (sec_low_i),
        .set_sel_i  (set_sel_i),
        .high_eff_o (high_eff),
        .low_eff_o  (low_eff)
    );

    cg_phase_core #(.CNT_W(CNT_W)) u_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_i),
        .enable_i     (enable_i),
        .high_eff_i   (high_eff),
        .low_eff_i    (low_eff),
        .carrier_o    (carrier_o),
        .period_end_o (period_end_o)
    );

    // R5: the picked counts are never zero
    a_r5_eff_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (high_eff != '0) && (low_eff != '0));

endmodule

// File: tb/carrier_gen_dual_bench.sv
module carrier_gen_dual_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       enable = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] ha = 8'd1, la = 8'd1, hb = 8'd1, lb = 8'd1;
    logic       carrier, pend;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    string cur_req = "R1";

    // tick-level reference model
    bit m_on  = 0;
    int m_pos = 0;
    int m_h   = 1;
    int m_l   = 1;
    bit m_pend = 0;

    always #2.5 clk = ~clk;

    carrier_gen_dual u_carrier_gen_dual (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_i       (tick),
        .enable_i     (enable),
        .pri_high_i   (ha),
        .pri_low_i    (la),
        .sec_high_i   (hb),
        .sec_low_i    (lb),
        .set_sel_i    (sel),
        .carrier_o    (carrier),
        .period_end_o (pend)
    );

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    function automatic bit exp_carrier();
        return m_on && (m_pos < m_h);
    endfunction

    task automatic latch_set();
        m_h = eff(sel ? hb : ha);
        m_l = eff(sel ? lb : la);
    endtask

    // Predict the effect of the coming edge from the inputs now applied.
    task automatic predict();
        m_pend = 0;
        if (!rst_n || !enable) begin
            m_on = 0;
            m_pos = 0;
        end else if (tick) begin
            if (!m_on) begin
                m_on = 1;
                m_pos = 0;
                latch_set();
            end else begin
                m_pos++;
                if (m_pos == m_h + m_l) begin
                    m_pos = 0;
                    m_pend = 1;
                    latch_set();
                end
            end
        end
    endtask

    task automatic check();
        vectors++;
        if (carrier !== exp_carrier()) begin
            misses++;
            $display("FAIL %s carrier actual=%0b expected=%0b at %0t", cur_req, carrier, exp_carrier(), $time);
        end
        vectors++;
        if (pend !== m_pend) begin
            misses++;
            $display("FAIL R6 period_end actual=%0b expected=%0b (during %s) at %0t", pend, m_pend, cur_req, $time);
        end
    endtask

    task automatic step();
        predict();
        @(negedge clk);
        check();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        misses++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        // R1: reset state
        cur_req = "R1";
        repeat (3) begin
            @(negedge clk);
            check();
        end
        rst_n = 1'b1;
        repeat (3) step();

        // R3 and R4: steady ticks, primary set 3/2
        cur_req = "R3";
        ha = 8'd3; la = 8'd2; enable = 1'b1; tick = 1'b1;
        repeat (12) step();
        cur_req = "R4";
        ha = 8'd2; la = 8'd5;
        repeat (20) step();

        // R9: sparse ticks
        cur_req = "R9";
        for (int i = 0; i < 200; i++) begin
            tick = ($urandom_range(0, 9) < 3);
            step();
        end
        tick = 1'b1;

        // R5: zero counts behave as one
        cur_req = "R5";
        ha = 8'd0; la = 8'd0;
        repeat (12) step();
        ha = 8'd0; la = 8'd3;
        repeat (12) step();

        // R7: select toggles at arbitrary cycles
        cur_req = "R7";
        ha = 8'd2; la = 8'd2; hb = 8'd5; lb = 8'd1;
        for (int i = 0; i < 90; i++) begin
            if (i % 3 == 0) sel = ~sel;
            step();
        end

        // R8: counts rewritten every cycle mid-period
        cur_req = "R8";
        sel = 1'b0;
        for (int i = 0; i < 120; i++) begin
            ha = 8'($urandom_range(1, 6));
            la = 8'($urandom_range(1, 6));
            step();
        end

        // R2: enable drops and returns
        cur_req = "R2";
        ha = 8'd4; la = 8'd3;
        for (int i = 0; i < 150; i++) begin
            enable = ($urandom_range(0, 9) < 7);
            step();
        end
        enable = 1'b1;

        // R6: long counts near the top of the range
        cur_req = "R6";
        ha = 8'd255; la = 8'd254;
        repeat (1100) step();

        // R7 mixed random: boundary-tick collisions of select and counts
        cur_req = "R7";
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(0, 19) == 0) sel = ~sel;
            if ($urandom_range(0, 29) == 0) ha = 8'($urandom_range(0, 7));
            if ($urandom_range(0, 29) == 0) la = 8'($urandom_range(0, 7));
            if ($urandom_range(0, 29) == 0) hb = 8'($urandom_range(0, 7));
            if ($urandom_range(0, 29) == 0) lb = 8'($urandom_range(0, 7));
            tick   = ($urandom_range(0, 3) != 0);
            enable = ($urandom_range(0, 199) != 0);
            step();
        end
        finish_run();
    end

endmodule